// File: doc/BRIEF.md
# Coprocessor Halt and Interrupt Control Register

This block is the host-visible control and status register bank of a small coprocessor. The host writes a word to one of four register slots. In the status slot, each piece of state is changed by its own pair of bits: one bit sets it and one bit clears it. The host can therefore start or stop the coprocessor, or raise or drop its interrupt, with a single write. It never has to read the register first and write back a merged value. A read of the status slot returns the halt and interrupt state together with two live flags from the coprocessor's DMA engine.

The pending interrupt only reaches the system interrupt line when the host has also enabled it in a separate mask slot. The mask slot uses the same set/clear encoding. A third slot reads back the gated interrupt line. The fourth slot holds the coprocessor's program counter. It stores only the implemented address width and forces word alignment, so the low two bits of any written value are dropped.

The write port acts on the clock edge. The read port is combinational on the address. The asynchronous active-low reset is re-timed inside the block, so its release takes effect on a clock edge.

Top module: `cop_ctrl_status`

## Requirements
- R1: After reset, halt is 1, the pending interrupt is 0, the mask is 0 and the program counter is 0. The status slot therefore reads 1 in bit 0 and 0 in bit 1, and `halt_o` is 1.
- R2: A write to the status slot (address 0) with bit 1 set and bit 0 clear sets halt. A write with bit 0 set and bit 1 clear clears halt. The status read shows halt in bit 0, and `halt_o` follows it.
- R3: A write to the status slot with bit 4 set and bit 3 clear sets the pending interrupt. A write with bit 3 set and bit 4 clear clears it. The status read shows the pending interrupt in bit 1.
- R4: When a write sets both bits of one pair (bits 0 and 1, bits 3 and 4, or mask bits 0 and 1), the state that pair controls keeps its previous value.
- R5: A status write that changes only the interrupt pair leaves halt unchanged. A status write that changes only the halt pair leaves the pending interrupt unchanged.
- R6: A write to the mask slot (address 1) with bit 1 set and bit 0 clear enables the mask. A write with bit 0 set and bit 1 clear disables it. The mask read shows the mask in bit 0.
- R7: `irq_o`, and bit 0 of the line slot (address 2), are 1 exactly when both the pending interrupt and the mask are 1.
- R8: Status read bits 2 and 3 show the `dma_busy` and `dma_full` inputs in the same cycle. Writing 1 to status bit 2 has no effect on any state. Unused read bits of every slot read 0.
- R9: A write to the PC slot (address 3) keeps write bits 11 to 2. The PC read returns them with bits 1 and 0 forced to 0 and all bits above 11 reading 0. For example, 0xABCD reads back as 0xBCC.
- R10: A write to one slot leaves the state held in the other slots unchanged, and the state does not change while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the slot selected by `addr` |
| addr | input | 2 | Slot select: 0 status, 1 mask, 2 interrupt line, 3 program counter |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data of the slot selected by `addr` |
| dma_busy | input | 1 | DMA engine busy flag |
| dma_full | input | 1 | DMA request queue full flag |
| halt_o | output | 1 | Halt state to the coprocessor pipeline |
| irq_o | output | 1 | Masked interrupt to the system interrupt controller |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and a 12-bit program counter with two alignment bits. This makes the discarded upper write bits of the PC visible, along with the zero upper read bits. Random 32-bit write words land on every combination of the two set/clear pairs, including the cases where both bits of a pair are set. Random values on the DMA flags check that the status read passes them straight through. Directed writes cover the example truncations of the PC and the case where the interrupt is cleared while halt is held.

// File: rtl/cop_csr_pkg.sv
package cop_csr_pkg;

  typedef enum logic [1:0] {
    SLOT_STATUS = 2'd0,
    SLOT_MASK   = 2'd1,
    SLOT_LINE   = 2'd2,
    SLOT_PC     = 2'd3
  } slot_e;

  // status write bit positions
  localparam int unsigned W_HALT_CLR = 0;
  localparam int unsigned W_HALT_SET = 1;
  localparam int unsigned W_IRQ_CLR  = 3;
  localparam int unsigned W_IRQ_SET  = 4;
  // mask write bit positions
  localparam int unsigned W_MASK_CLR = 0;
  localparam int unsigned W_MASK_SET = 1;
  // status read bit positions
  localparam int unsigned R_HALT     = 0;
  localparam int unsigned R_IRQ      = 1;
  localparam int unsigned R_BUSY     = 2;
  localparam int unsigned R_FULL     = 3;

endpackage

// File: rtl/cop_rst_sync.sv
module cop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cop_setclr_bit.sv
module cop_setclr_bit #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic state_q;
  logic state_d;
  logic state_en;

  always_comb begin
    state_en = set_i ^ clr_i;
    state_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= RESET_VAL;
    else if (state_en) state_q <= state_d;
  end

  assign q_o = state_q;

  // R4
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> $stable(q_o));
  // R2
  set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);
  // R2
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/cop_pc_reg.sv
module cop_pc_reg #(
  parameter int unsigned PC_W  = 12,
  parameter int unsigned ALIGN = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [PC_W-1:ALIGN]   data_i,
  output logic [PC_W-1:0]       pc_o
);
  localparam int unsigned KEEP_W = PC_W - ALIGN;

  logic [KEEP_W-1:0] pc_q;
  logic [KEEP_W-1:0] pc_d;

  always_comb begin
    pc_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (wr_i) pc_q <= pc_d;
  end

  assign pc_o = {pc_q, {ALIGN{1'b0}}};

  // R9
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (pc_o[PC_W-1:ALIGN] == $past(data_i)));
  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(pc_o));
endmodule

// File: rtl/cop_ctrl_status.sv
module cop_ctrl_status
  import cop_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 12,
  parameter int unsigned ALIGN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dma_busy,
  input  logic              dma_full,
  output logic              halt_o,
  output logic              irq_o
);
  logic rst_i_n;
  logic wr_status, wr_mask, wr_pc;
  logic halt_q, irq_q, mask_q;
  logic [PC_W-1:0] pc_val;
  logic unused_wdata;

  cop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    wr_status = wr_en && (slot_e'(addr) == SLOT_STATUS);
    wr_mask   = wr_en && (slot_e'(addr) == SLOT_MASK);
    wr_pc     = wr_en && (slot_e'(addr) == SLOT_PC);
  end

  cop_setclr_bit #(.RESET_VAL(1'b1)) u_halt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_i (wr_status && wr_data[W_HALT_SET]),
    .clr_i (wr_status && wr_data[W_HALT_CLR]),
    .q_o   (halt_q)
  );

  cop_setclr_bit #(.RESET_VAL(1'b0)) u_irq (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_i (wr_status && wr_data[W_IRQ_SET]),
    .clr_i (wr_status && wr_data[W_IRQ_CLR]),
    .q_o   (irq_q)
  );

  cop_setclr_bit #(.RESET_VAL(1'b0)) u_mask (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_i (wr_mask && wr_data[W_MASK_SET]),
    .clr_i (wr_mask && wr_data[W_MASK_CLR]),
    .q_o   (mask_q)
  );

  cop_pc_reg #(.PC_W(PC_W), .ALIGN(ALIGN)) u_pc (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr_i   (wr_pc),
    .data_i (wr_data[PC_W-1:ALIGN]),
    .pc_o   (pc_val)
  );

  assign unused_wdata = ^{wr_data[DATA_W-1:PC_W], wr_data[ALIGN-1:0]};

  always_comb begin
    rd_data = '0;
    unique case (slot_e'(addr))
      SLOT_STATUS: begin
        rd_data[R_HALT] = halt_q;
        rd_data[R_IRQ]  = irq_q;
        rd_data[R_BUSY] = dma_busy;
        rd_data[R_FULL] = dma_full;
      end
      SLOT_MASK: rd_data[0] = mask_q;
      SLOT_LINE: rd_data[0] = irq_q & mask_q;
      SLOT_PC:   rd_data[PC_W-1:0] = pc_val;
      default:   rd_data = '0;
    endcase
  end

  assign halt_o = halt_q;
  assign irq_o  = irq_q & mask_q;

  // R5
  irq_write_keeps_halt_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_status && !wr_data[W_HALT_SET] && !wr_data[W_HALT_CLR]) |=> $stable(halt_o));
  // R7
  line_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq_o |-> mask_q);
  // R10
  mask_write_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en && (addr != 2'd0)) |=> ($stable(halt_o) && $stable(irq_q)));
  // R1
  reset_halted_chk: assert property (@(posedge clk)
    $rose(rst_i_n) |-> (halt_o && !irq_o));
endmodule

// File: tb/sim_cop_ctrl_status.sv
module sim_cop_ctrl_status;
  localparam int unsigned DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic dma_busy = 1'b0;
  logic dma_full = 1'b0;
  logic halt_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic m_halt, m_irq, m_mask;
  logic [11:0] m_pc;

  cop_ctrl_status u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .dma_busy(dma_busy),
    .dma_full(dma_full), .halt_o(halt_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fail = n_fail + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic pair(input logic cur, input logic s, input logic c);
    if (s && !c) return 1'b1;
    if (c && !s) return 1'b0;
    return cur;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
    logic [DW-1:0] v = '0;
    case (a)
      2'd0: v[3:0] = {dma_full, dma_busy, m_irq, m_halt};
      2'd1: v[0] = m_mask;
      2'd2: v[0] = m_irq & m_mask;
      default: v[11:0] = m_pc;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #1;
      check(tag, rd_data, exp_read(2'(a)));
    end
    check({tag, " halt_o R2"}, {31'b0, halt_o}, {31'b0, m_halt});
    check({tag, " irq_o R7"}, {31'b0, irq_o}, {31'b0, m_irq & m_mask});
  endtask

  task automatic do_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: begin
        m_halt = pair(m_halt, d[1], d[0]);
        m_irq  = pair(m_irq, d[4], d[3]);
      end
      2'd1: m_mask = pair(m_mask, d[1], d[0]);
      2'd3: m_pc = {d[11:2], 2'b00};
      default: ;
    endcase
  endtask

  initial begin
    void'($urandom(32'h5eed));
    m_halt = 1'b1; m_irq = 1'b0; m_mask = 1'b0; m_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");

    do_write(2'd0, 32'h0000_0001); check_all("R2 clear halt");
    do_write(2'd0, 32'h0000_0002); check_all("R2 set halt");
    do_write(2'd1, 32'h0000_0002); check_all("R6 set mask");
    do_write(2'd0, 32'h0000_0010); check_all("R3 set irq");
    do_write(2'd0, 32'h0000_0008); check_all("R5 clear irq keeps halt");
    do_write(2'd0, 32'h0000_001B); check_all("R4 both pairs hold");
    do_write(2'd0, 32'h0000_0004); check_all("R8 bit2 write ignored");
    dma_busy = 1'b1; dma_full = 1'b0; check_all("R8 busy");
    dma_busy = 1'b0; dma_full = 1'b1; check_all("R8 full");
    do_write(2'd3, 32'h0000_ABCD); check_all("R9 pc abcd");
    do_write(2'd3, 32'h0000_8BC4); check_all("R9 pc 8bc4");
    do_write(2'd3, 32'h0000_0F22); check_all("R9 pc f22");
    do_write(2'd2, 32'hFFFF_FFFF); check_all("R10 line slot write");
    do_write(2'd1, 32'h0000_0003); check_all("R4 mask both");
    do_write(2'd1, 32'h0000_0001); check_all("R6 clear mask");

    for (int i = 0; i < 400; i++) begin
      dma_busy = 1'($urandom);
      dma_full = 1'($urandom);
      if ($urandom % 4 != 0)
        do_write(2'($urandom), $urandom);
      else begin
        @(negedge clk);
        wr_data = $urandom; addr = 2'($urandom);
        @(negedge clk);
      end
      check_all("R10 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule